// File: doc/BRIEF.md
# OTG line status tracker

This block maintains a 16-bit, read-only OTG line status word from two level inputs that arrive without any timing relation to the local clock. One input reports whether VBUS is valid. The other reports whether a session is active. Each input first passes through a multi-flop synchronizer. A change detector then turns every real change of the synchronized level into update strobes for a small status datapath.

A VBUS-valid change updates one status bit. It also produces a single-cycle change event, which the interrupt aggregator takes as its VBUS-sense-change source. A session change sets one bit of a complementary pair and clears the other. A session change never produces an event. The line-state, host-disconnect, ID and VBUS-sense fields are not driven by this block and always read as zero. Because an ID status of zero means host mode, the word after reset describes a host with no VBUS and no session.

Top module: `otg_line_status`

## Requirements
- R1: While reset is asserted (rstN low), statusWord is 16'h0000 and vbusChgPulse is 0.
- R2: statusWord bit 5 equals the VBUS-valid level sampled three rising clock edges earlier, counting two synchronizer flops and the status register.
- R3: vbusChgPulse is high for exactly one cycle, in the same cycle that bit 5 takes a new value. It stays low while the VBUS level holds steady, whether high or low.
- R4: When the synchronized session level rises, bit 6 (session valid) becomes 1 and bit 7 (session end) becomes 0, three edges after the input sample.
- R5: When the synchronized session level falls, bit 6 becomes 0 and bit 7 becomes 1, three edges after the input sample.
- R6: A session change, whether a rise or a fall, never produces a pulse on vbusChgPulse.
- R7: Bits 4:0 and bits 15:8 of statusWord always read as zero.
- R8: Bits 6 and 7 are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vbusLvl | input | 1 | VBUS-valid level, asynchronous to clk |
| sessLvl | input | 1 | Session level, asynchronous to clk |
| statusWord | output | 16 | Read-only OTG status word |
| vbusChgPulse | output | 1 | One-cycle event on each VBUS-valid change |

## Verification
Every result of this block is due on the third rising edge after the input sample. That edge count covers two synchronizer flops and one register that updates the status word and the event pulse together. The bench keeps a behavioural model that advances on the same edges. It compares all of statusWord and vbusChgPulse 3 ns after every rising edge, so the outputs have settled and the next input change, which is made on the falling edge, has not yet happened. Every check sits at that one fixed offset after the edge on which the design and the model both update.

// File: rtl/otg_status_pkg.sv
package otg_status_pkg;
  // Update requests sent from the change detector to the status datapath.
  typedef struct packed {
    logic vbusSet;
    logic vbusClr;
    logic sessSet;
    logic sessClr;
  } statusStrobes_t;
endpackage

// File: rtl/otg_sync.sv
module otg_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= '0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= '0;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/otg_status_ctrl.sv
module otg_status_ctrl
  import otg_status_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           syncVbus,
  input  logic           syncSess,
  output statusStrobes_t strobes,
  output logic           chgPulse
);
  logic prevVbus, prevSess;
  logic vbusEdge, sessEdge;

  assign vbusEdge = syncVbus ^ prevVbus;
  assign sessEdge = syncSess ^ prevSess;

  always_comb begin
    strobes.vbusSet = vbusEdge &  syncVbus;
    strobes.vbusClr = vbusEdge & ~syncVbus;
    strobes.sessSet = sessEdge &  syncSess;
    strobes.sessClr = sessEdge & ~syncSess;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevVbus <= 1'b0;
      prevSess <= 1'b0;
      chgPulse <= 1'b0;
    end else begin
      prevVbus <= syncVbus;
      prevSess <= syncSess;
      chgPulse <= vbusEdge;
    end
  end

  // R3: a set request and a clear request for the same bit never come together
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.vbusSet, strobes.vbusClr}));
  // R6: the pulse follows only a VBUS request, never a session request alone
  p_sess_no_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sessEdge && !vbusEdge) |=> !chgPulse);
endmodule

// File: rtl/otg_status_dp.sv
module otg_status_dp
  import otg_status_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int VBUS_BIT   = 5,
  parameter int SVALID_BIT = 6,
  parameter int SEND_BIT   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  statusStrobes_t    strobes,
  output logic [WORD_W-1:0] word
);
  localparam logic [WORD_W-1:0] LIVE_MASK =
    (WORD_W'(1) << VBUS_BIT) | (WORD_W'(1) << SVALID_BIT) | (WORD_W'(1) << SEND_BIT);

  logic vbusQ, sessValidQ, sessEndQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vbusQ      <= 1'b0;
      sessValidQ <= 1'b0;
      sessEndQ   <= 1'b0;
    end else begin
      if (strobes.vbusSet)      vbusQ <= 1'b1;
      else if (strobes.vbusClr) vbusQ <= 1'b0;
      if (strobes.sessSet) begin
        sessValidQ <= 1'b1;
        sessEndQ   <= 1'b0;
      end else if (strobes.sessClr) begin
        sessValidQ <= 1'b0;
        sessEndQ   <= 1'b1;
      end
    end
  end

  always_comb begin
    word             = '0;
    word[VBUS_BIT]   = vbusQ;
    word[SVALID_BIT] = sessValidQ;
    word[SEND_BIT]   = sessEndQ;
  end

  // R8: session valid and session end are never both set
  p_sess_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(word[SVALID_BIT] && word[SEND_BIT]));
  // R7: bits outside the three live fields stay zero
  p_fixed_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (word & ~LIVE_MASK) == '0);
  // R4: a session rise request leaves the pair at valid=1, end=0
  p_sess_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sessSet |=> (word[SVALID_BIT] && !word[SEND_BIT]));
  // R5: a session fall request leaves the pair at valid=0, end=1
  p_sess_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sessClr |=> (!word[SVALID_BIT] && word[SEND_BIT]));
endmodule

// File: rtl/otg_line_status.sv
module otg_line_status
  import otg_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 16,
  parameter int VBUS_BIT    = 5,
  parameter int SVALID_BIT  = 6,
  parameter int SEND_BIT    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vbusLvl,
  input  logic              sessLvl,
  output logic [WORD_W-1:0] statusWord,
  output logic              vbusChgPulse
);
  logic [1:0]     syncLvl;
  statusStrobes_t strobes;

  otg_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn({sessLvl, vbusLvl}), .syncOut(syncLvl));

  otg_status_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .syncVbus(syncLvl[0]), .syncSess(syncLvl[1]),
    .strobes(strobes), .chgPulse(vbusChgPulse));

  otg_status_dp #(.WORD_W(WORD_W), .VBUS_BIT(VBUS_BIT), .SVALID_BIT(SVALID_BIT),
    .SEND_BIT(SEND_BIT)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .word(statusWord));

  // R3: the event is high exactly in the cycles where the VBUS bit has just changed
  p_pulse_on_change_r3: assert property (@(posedge clk) disable iff (!rstN)
    vbusChgPulse == (statusWord[VBUS_BIT] != $past(statusWord[VBUS_BIT])));
  // R6: a session-only change of the word carries no event
  p_sess_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((statusWord[SVALID_BIT] != $past(statusWord[SVALID_BIT])) &&
     $stable(statusWord[VBUS_BIT])) |-> !vbusChgPulse);
endmodule

// File: tb/otg_line_status_test.sv
module otg_line_status_test;
  logic clk = 1'b0, rstN = 1'b0, vbusLvl = 1'b0, sessLvl = 1'b0;
  logic [15:0] statusWord;
  logic vbusChgPulse;
  int checks = 0, failures = 0;

  otg_line_status uut (.clk(clk), .rstN(rstN), .vbusLvl(vbusLvl), .sessLvl(sessLvl),
    .statusWord(statusWord), .vbusChgPulse(vbusChgPulse));

  always #5 clk = ~clk;

  // Behavioural reference: an input sample reaches the word after three edges.
  bit sampV[3], sampS[3];
  bit expV, expPulse, expSV, expSE, lastS, sessMoved;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin sampV[i] = 0; sampS[i] = 0; end
      expV = 0; expPulse = 0; expSV = 0; expSE = 0; lastS = 0; sessMoved = 0;
    end else begin
      for (int i = 2; i > 0; i--) begin sampV[i] = sampV[i-1]; sampS[i] = sampS[i-1]; end
      sampV[0] = vbusLvl; sampS[0] = sessLvl;
      expPulse = (sampV[2] != expV);
      expV = sampV[2];
      sessMoved = (sampS[2] != lastS);
      if (sessMoved) begin expSV = sampS[2]; expSE = !sampS[2]; end
      lastS = sampS[2];
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (!rstN) begin
      check("R1 word", statusWord, 16'h0000);
      check("R1 pulse", {15'b0, vbusChgPulse}, 16'h0000);
    end else begin
      check("R2 vbus bit5", {15'b0, statusWord[5]}, {15'b0, expV});
      if (sessMoved && !expPulse) check("R6 pulse", {15'b0, vbusChgPulse}, 16'h0000);
      else check("R3 pulse", {15'b0, vbusChgPulse}, {15'b0, expPulse});
      if (expSV) check("R4 bits7:6", {14'b0, statusWord[7:6]}, {14'b0, expSE, expSV});
      else       check("R5 bits7:6", {14'b0, statusWord[7:6]}, {14'b0, expSE, expSV});
      check("R7 fixed bits", statusWord & 16'hff1f, 16'h0000);
      check("R8 pair", {15'b0, statusWord[6] & statusWord[7]}, 16'h0000);
    end
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    hold(4);
    rstN = 1'b1;
    hold(6);
    vbusLvl = 1; hold(10);          // R2/R3 rise, then steady high
    vbusLvl = 0; hold(10);          // fall, then steady low
    sessLvl = 1; hold(8);           // R4 with no pulse, R6
    sessLvl = 0; hold(8);           // R5
    sessLvl = 1; vbusLvl = 1; hold(8);
    for (int i = 0; i < 10; i++) begin vbusLvl = ~vbusLvl; hold(1); end
    for (int i = 0; i < 10; i++) begin vbusLvl = ~vbusLvl; hold(2); end
    vbusLvl = 0; hold(5);
    vbusLvl = 1; hold(1); vbusLvl = 0; hold(6);   // one-cycle glitch
    sessLvl = 0; hold(1); sessLvl = 1; hold(6);
    vbusLvl = 1; sessLvl = 1;
    rstN = 1'b0; hold(3);           // R1 mid-run reset with inputs high
    rstN = 1'b1; hold(8);
    for (int i = 0; i < 120; i++) begin
      vbusLvl = ((i % 7) < 3);
      sessLvl = ((i % 5) < 2);
      hold(1);
    end
    hold(6);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule